// File: doc/BRIEF.md
# TDMA Receiver Doze Scheduler

This block sits in a mobile terminal whose air time is shared out by a base station in variable-length TDMA frames. Each frame opens with a control cell, followed by data slots. The control cell says which terminals own which data slots, in which direction, and after how many slots the next control cell will come. The scheduler keeps the receiver on while it hunts for a control cell. It decodes the cell as it streams in and works out this terminal's own receive and transmit slots. It then powers the radio only for those slots and for the approach of the next control cell, and dozes in between.

The decoded cell arrives as a stream of words with a valid strobe, start and end markers and a per-word error flag. Slot boundaries come from a slot tick. A warm-up lead input raises an enable that many slot positions before the slot that needs it. Slots that are adjacent or overlapping form one burst, so the radio does not toggle inside it. A cell that is damaged, inconsistent or missing leaves the receiver on until a good cell is taken.

Top module: `tdma_doze_sched`

## Requirements
- R1: After reset the block is hunting. rx_en is 1, and tx_en, rx_slot and tx_slot are 0. Slot ticks while hunting change nothing.
- R2: A cell is a header word (cc_sof=1) followed by records, with cc_eof on the last word. Header bits [SLOT_W-1:0] give the next-cell offset in slots; the remaining upper bits give the record count. A record holds the terminal ID in bits [ID_W-1:0], the start slot in the next SLOT_W bits, the slot count in the next SLOT_W bits, and the direction in the top bit (1 = transmit, 0 = receive). A cell taken while hunting is accepted at the clock edge of its cc_eof word. A header-only cell (cc_sof and cc_eof together, count 0) is valid.
- R3: When an accepted cell holds no record for own_id, tx_en falls the cycle after cc_eof. rx_en falls too, unless the next cell is already inside the lead window.
- R4: The frame position is 0 at acceptance and rises by one per slot_tick. rx_slot is 1 while the position lies in one of this terminal's receive records; tx_slot does the same for transmit records.
- R5: rx_en is 1 when any own receive slot lies within [position, position+lead_ticks]. tx_en follows the same rule for own transmit slots.
- R6: Adjacent or overlapping own records of one direction keep that enable high without a gap across the whole merged run.
- R7: rx_en is 1 from position next_offset−lead_ticks onward. The tick that would reach next_offset returns the block to hunting (R1 outputs). With no good cell it stays hunting indefinitely.
- R8: A cell is discarded, and the block keeps hunting with rx_en=1, when any of its words has cc_bad set, when the record count seen differs from the header's count, or when its offset is 0.
- R9: Words that arrive while a frame is scheduled (not hunting) have no effect on the outputs.
- R10: Record slots at position 0, or at or beyond next_offset, never become active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_tick | input | 1 | One-cycle pulse per slot boundary |
| cc_valid | input | 1 | Control-cell word strobe |
| cc_sof | input | 1 | Marks the header word |
| cc_eof | input | 1 | Marks the last word of the cell |
| cc_bad | input | 1 | Decoder flagged this word as corrupted |
| cc_word | input | WORD_W | Control-cell word (header or record) |
| own_id | input | ID_W | This terminal's identifier |
| lead_ticks | input | SLOT_W | Warm-up lead in slots |
| rx_en | output | 1 | Receiver power enable |
| tx_en | output | 1 | Transmitter power enable |
| rx_slot | output | 1 | Current slot is an own receive slot |
| tx_slot | output | 1 | Current slot is an own transmit slot |

## Verification
The bench aims at cells that must be thrown away: a flagged word, a short record list, a zero offset. A design that trusted them would shut the receiver and lose the frame. It sends a full cell in the middle of a scheduled frame; a design that listened would replace the schedule and wake at the wrong slots. Abutting and overlapping records test the merge, because a per-record enable would drop for a cycle between bursts. Records that start in slot 0 or reach past the next offset test the clipping. Lead values that reach the next cell test whether the receiver comes up early. Random frames mixed across terminals, directions and lead values are compared each slot against a model built from the requirements.

// File: rtl/tdma_doze_pkg.sv
package tdma_doze_pkg;
  typedef enum logic {
    ST_HUNT  = 1'b0,
    ST_SCHED = 1'b1
  } doze_state_e;
endpackage

// File: rtl/cell_decoder.sv
module cell_decoder #(
  parameter int ID_W   = 6,
  parameter int SLOT_W = 4,
  parameter int WORD_W = ID_W + 2*SLOT_W + 1,
  parameter int NSLOT  = 1 << SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              listen,
  input  logic              cc_valid,
  input  logic              cc_sof,
  input  logic              cc_eof,
  input  logic              cc_bad,
  input  logic [WORD_W-1:0] cc_word,
  input  logic [ID_W-1:0]   own_id,
  output logic              commit,
  output logic [NSLOT-1:0]  new_rx,
  output logic [NSLOT-1:0]  new_tx,
  output logic [SLOT_W-1:0] new_off
);
  localparam int CNT_W = WORD_W - SLOT_W;

  logic              in_cell_q, err_q;
  logic [CNT_W-1:0]  seen_q, exp_q;
  logic [SLOT_W-1:0] off_q;
  logic [NSLOT-1:0]  rx_acc_q, tx_acc_q;

  logic              in_cell_d, err_d;
  logic [CNT_W-1:0]  seen_d, exp_d;
  logic [SLOT_W-1:0] off_d;
  logic [NSLOT-1:0]  rx_acc_d, tx_acc_d;

  logic              take;
  logic [ID_W-1:0]   rec_id;
  logic [SLOT_W-1:0] rec_start, rec_len;
  logic              rec_dir;
  logic [SLOT_W:0]   span_end;
  logic [NSLOT-1:0]  span, keep;
  logic [SLOT_W:0]   idx;

  // field split and the slot span of the current record
  always_comb begin
    rec_id    = cc_word[ID_W-1:0];
    rec_start = cc_word[ID_W+SLOT_W-1:ID_W];
    rec_len   = cc_word[ID_W+2*SLOT_W-1:ID_W+SLOT_W];
    rec_dir   = cc_word[WORD_W-1];
    span_end  = {1'b0, rec_start} + {1'b0, rec_len};
    for (int i = 0; i < NSLOT; i++) begin
      idx     = (SLOT_W+1)'(i);
      span[i] = (idx >= {1'b0, rec_start}) && (idx < span_end);
    end
  end

  // next state of the shadow accumulator
  always_comb begin
    take      = cc_valid & listen;
    in_cell_d = in_cell_q;
    err_d     = err_q;
    seen_d    = seen_q;
    exp_d     = exp_q;
    off_d     = off_q;
    rx_acc_d  = rx_acc_q;
    tx_acc_d  = tx_acc_q;
    if (take) begin
      if (cc_sof) begin
        err_d     = cc_bad;
        seen_d    = '0;
        exp_d     = cc_word[WORD_W-1:SLOT_W];
        off_d     = cc_word[SLOT_W-1:0];
        rx_acc_d  = '0;
        tx_acc_d  = '0;
        in_cell_d = ~cc_eof;
      end else if (in_cell_q) begin
        err_d = err_q | cc_bad;
        if (seen_q != {CNT_W{1'b1}}) seen_d = seen_q + 1'b1;
        if (rec_id == own_id) begin
          if (rec_dir) tx_acc_d = tx_acc_q | span;
          else         rx_acc_d = rx_acc_q | span;
        end
        in_cell_d = ~cc_eof;
      end
    end
  end

  // acceptance and clipping to the data slots of this frame
  always_comb begin
    for (int i = 0; i < NSLOT; i++) begin
      keep[i] = (i != 0) && ((SLOT_W+1)'(i) < {1'b0, off_d});
    end
    commit  = take & cc_eof & (cc_sof | in_cell_q) & ~err_d &
              (seen_d == exp_d) & (off_d != '0);
    new_rx  = rx_acc_d & keep;
    new_tx  = tx_acc_d & keep;
    new_off = off_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cell_q <= 1'b0;
      err_q     <= 1'b0;
      seen_q    <= '0;
      exp_q     <= '0;
      off_q     <= '0;
      rx_acc_q  <= '0;
      tx_acc_q  <= '0;
    end else if (take) begin
      in_cell_q <= in_cell_d;
      err_q     <= err_d;
      seen_q    <= seen_d;
      exp_q     <= exp_d;
      off_q     <= off_d;
      rx_acc_q  <= rx_acc_d;
      tx_acc_q  <= tx_acc_d;
    end
  end
endmodule

// File: rtl/frame_timer.sv
module frame_timer
  import tdma_doze_pkg::*;
#(
  parameter int SLOT_W = 4,
  parameter int NSLOT  = 1 << SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_tick,
  input  logic              commit,
  input  logic [NSLOT-1:0]  new_rx,
  input  logic [NSLOT-1:0]  new_tx,
  input  logic [SLOT_W-1:0] new_off,
  output logic              hunt,
  output logic [SLOT_W-1:0] pos,
  output logic [SLOT_W-1:0] frame_off,
  output logic [NSLOT-1:0]  rx_mask,
  output logic [NSLOT-1:0]  tx_mask
);
  doze_state_e       state_q, state_d;
  logic [SLOT_W-1:0] pos_q, pos_d;
  logic [SLOT_W:0]   pos_inc;
  logic              load;

  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    load    = 1'b0;
    pos_inc = {1'b0, pos_q} + 1'b1;
    if (state_q == ST_HUNT) begin
      if (commit) begin
        state_d = ST_SCHED;
        pos_d   = '0;
        load    = 1'b1;
      end
    end else if (slot_tick) begin
      if (pos_inc == {1'b0, frame_off}) begin
        state_d = ST_HUNT;
        pos_d   = '0;
      end else begin
        pos_d = pos_inc[SLOT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      pos_q   <= '0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_off <= '0;
      rx_mask   <= '0;
      tx_mask   <= '0;
    end else if (load) begin
      frame_off <= new_off;
      rx_mask   <= new_rx;
      tx_mask   <= new_tx;
    end
  end

  assign hunt = (state_q == ST_HUNT);
  assign pos  = pos_q;
endmodule

// File: rtl/wake_window.sv
module wake_window #(
  parameter int SLOT_W = 4,
  parameter int NSLOT  = 1 << SLOT_W
) (
  input  logic              hunt,
  input  logic [SLOT_W-1:0] pos,
  input  logic [SLOT_W-1:0] lead,
  input  logic [SLOT_W-1:0] frame_off,
  input  logic [NSLOT-1:0]  rx_mask,
  input  logic [NSLOT-1:0]  tx_mask,
  output logic              rx_en,
  output logic              tx_en,
  output logic              rx_slot,
  output logic              tx_slot
);
  logic [SLOT_W:0]  reach, idx;
  logic [NSLOT-1:0] inwin;
  logic             cc_near;

  always_comb begin
    reach = {1'b0, pos} + {1'b0, lead};
    for (int i = 0; i < NSLOT; i++) begin
      idx      = (SLOT_W+1)'(i);
      inwin[i] = (idx >= {1'b0, pos}) && (idx <= reach);
    end
    cc_near = (reach >= {1'b0, frame_off});
    rx_en   = hunt | cc_near | (|(rx_mask & inwin));
    tx_en   = ~hunt & (|(tx_mask & inwin));
    rx_slot = ~hunt & rx_mask[pos];
    tx_slot = ~hunt & tx_mask[pos];
  end
endmodule

// File: rtl/tdma_doze_sched.sv
module tdma_doze_sched #(
  parameter  int ID_W   = 6,
  parameter  int SLOT_W = 4,
  localparam int WORD_W = ID_W + 2*SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_tick,
  input  logic              cc_valid,
  input  logic              cc_sof,
  input  logic              cc_eof,
  input  logic              cc_bad,
  input  logic [WORD_W-1:0] cc_word,
  input  logic [ID_W-1:0]   own_id,
  input  logic [SLOT_W-1:0] lead_ticks,
  output logic              rx_en,
  output logic              tx_en,
  output logic              rx_slot,
  output logic              tx_slot
);
  localparam int NSLOT = 1 << SLOT_W;

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic              hunt, commit;
  logic [SLOT_W-1:0] pos, frame_off, new_off;
  logic [NSLOT-1:0]  rx_mask, tx_mask, new_rx, new_tx;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  cell_decoder #(.ID_W(ID_W), .SLOT_W(SLOT_W), .WORD_W(WORD_W), .NSLOT(NSLOT)) u_dec (
    .clk(clk), .rst_n(rst_sync_n), .listen(hunt),
    .cc_valid(cc_valid), .cc_sof(cc_sof), .cc_eof(cc_eof), .cc_bad(cc_bad),
    .cc_word(cc_word), .own_id(own_id),
    .commit(commit), .new_rx(new_rx), .new_tx(new_tx), .new_off(new_off)
  );

  frame_timer #(.SLOT_W(SLOT_W), .NSLOT(NSLOT)) u_tmr (
    .clk(clk), .rst_n(rst_sync_n), .slot_tick(slot_tick), .commit(commit),
    .new_rx(new_rx), .new_tx(new_tx), .new_off(new_off),
    .hunt(hunt), .pos(pos), .frame_off(frame_off),
    .rx_mask(rx_mask), .tx_mask(tx_mask)
  );

  wake_window #(.SLOT_W(SLOT_W), .NSLOT(NSLOT)) u_win (
    .hunt(hunt), .pos(pos), .lead(lead_ticks), .frame_off(frame_off),
    .rx_mask(rx_mask), .tx_mask(tx_mask),
    .rx_en(rx_en), .tx_en(tx_en), .rx_slot(rx_slot), .tx_slot(tx_slot)
  );
endmodule

// File: rtl/tdma_doze_sched_chk.sv
module tdma_doze_sched_chk #(
  parameter int SLOT_W = 4,
  parameter int NSLOT  = 1 << SLOT_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slot_tick,
  input logic              cc_valid,
  input logic              cc_bad,
  input logic              commit,
  input logic              hunt,
  input logic [SLOT_W-1:0] pos,
  input logic [SLOT_W-1:0] frame_off,
  input logic [NSLOT-1:0]  rx_mask,
  input logic [NSLOT-1:0]  tx_mask,
  input logic              rx_en,
  input logic              tx_en,
  input logic              rx_slot,
  input logic              tx_slot
);
  p_rx_slot_powered_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_slot |-> rx_en);
  p_tx_slot_powered_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_slot |-> tx_en);
  p_pos_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hunt && !slot_tick) |=> $stable(pos));
  p_accept_starts_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (!hunt && pos == '0 && frame_off != '0));
  p_hunt_listens_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hunt |-> (rx_en && !tx_en));
  p_pos_below_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hunt |-> (pos < frame_off));
  p_bad_keeps_hunting_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hunt && cc_valid && cc_bad) |=> (hunt && rx_en));
  p_sched_ignores_cells_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !hunt |=> ($stable(rx_mask) && $stable(tx_mask) && $stable(frame_off)));
  p_slot0_never_used_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_mask[0] && !tx_mask[0]);
endmodule

bind tdma_doze_sched tdma_doze_sched_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .slot_tick(slot_tick), .cc_valid(cc_valid),
  .cc_bad(cc_bad), .commit(commit), .hunt(hunt), .pos(pos),
  .frame_off(frame_off), .rx_mask(rx_mask), .tx_mask(tx_mask),
  .rx_en(rx_en), .tx_en(tx_en), .rx_slot(rx_slot), .tx_slot(tx_slot)
);

// File: tb/tdma_doze_sched_bench.sv
module tdma_doze_sched_bench;
  localparam int ID_W   = 6;
  localparam int SLOT_W = 4;
  localparam int WORD_W = ID_W + 2*SLOT_W + 1;
  localparam int OWN    = 21;

  logic clk, rst_n, slot_tick, cc_valid, cc_sof, cc_eof, cc_bad;
  logic [WORD_W-1:0] cc_word;
  logic [ID_W-1:0]   own_id;
  logic [SLOT_W-1:0] lead_ticks;
  logic rx_en, tx_en, rx_slot, tx_slot;

  tdma_doze_sched #(.ID_W(ID_W), .SLOT_W(SLOT_W)) u_tdma_doze_sched (
    .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .cc_valid(cc_valid),
    .cc_sof(cc_sof), .cc_eof(cc_eof), .cc_bad(cc_bad), .cc_word(cc_word),
    .own_id(own_id), .lead_ticks(lead_ticks),
    .rx_en(rx_en), .tx_en(tx_en), .rx_slot(rx_slot), .tx_slot(tx_slot)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk, n_bad, cyc;
  bit done;

  // bench model of the schedule
  bit m_hunt;
  int m_pos, m_off;
  logic [15:0] m_rx, m_tx;
  int r_id[16], r_st[16], r_ln[16], r_dir[16];
  int nrec;

  function automatic logic [WORD_W-1:0] mkrec(int id, int st, int ln, int dir);
    return WORD_W'((dir << (ID_W+2*SLOT_W)) | (ln << (ID_W+SLOT_W)) | (st << ID_W) | id);
  endfunction

  function automatic logic [3:0] expect_outs();
    int reach;
    logic r, t;
    if (m_hunt) return 4'b1000;
    reach = m_pos + int'(lead_ticks);
    r = (reach >= m_off);
    t = 1'b0;
    for (int i = 0; i < 16; i++)
      if (i >= m_pos && i <= reach) begin r |= m_rx[i]; t |= m_tx[i]; end
    return {r, t, m_rx[m_pos], m_tx[m_pos]};
  endfunction

  task automatic check_outs(string tag);
    logic [3:0] exp_v, act;
    exp_v = expect_outs();
    act   = {rx_en, tx_en, rx_slot, tx_slot};
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s pos=%0d {rx_en,tx_en,rx_slot,tx_slot} actual=%b expected=%b",
               tag, m_pos, act, exp_v);
    end
  endtask

  task automatic check_bit(string tag, logic act, logic exp_b);
    n_chk++;
    if (act !== exp_b) begin
      n_bad++;
      $display("FAIL %s pos=%0d actual=%b expected=%b", tag, m_pos, act, exp_b);
    end
  endtask

  task automatic add_rec(int id, int st, int ln, int dir);
    r_id[nrec] = id; r_st[nrec] = st; r_ln[nrec] = ln; r_dir[nrec] = dir;
    nrec++;
  endtask

  task automatic send_cell(int cnt, int off, int bad_at);
    @(negedge clk);
    cc_valid = 1'b1; cc_sof = 1'b1; cc_eof = (nrec == 0); cc_bad = (bad_at == 0);
    cc_word  = WORD_W'((cnt << SLOT_W) | off);
    for (int k = 0; k < nrec; k++) begin
      @(negedge clk);
      cc_sof = 1'b0; cc_eof = (k == nrec-1); cc_bad = (bad_at == k+1);
      cc_word = mkrec(r_id[k], r_st[k], r_ln[k], r_dir[k]);
    end
    @(negedge clk);
    cc_valid = 1'b0; cc_sof = 1'b0; cc_eof = 1'b0; cc_bad = 1'b0;
    if (m_hunt && bad_at < 0 && cnt == nrec && off != 0) begin
      m_hunt = 1'b0; m_pos = 0; m_off = off; m_rx = '0; m_tx = '0;
      for (int k = 0; k < nrec; k++)
        if (r_id[k] == OWN)
          for (int i = 1; i < off; i++)
            if (i >= r_st[k] && i < r_st[k] + r_ln[k]) begin
              if (r_dir[k] != 0) m_tx[i] = 1'b1; else m_rx[i] = 1'b1;
            end
    end
    nrec = 0;
  endtask

  task automatic tick(string tag);
    slot_tick = 1'b1;
    @(negedge clk);
    slot_tick = 1'b0;
    if (!m_hunt) begin
      if (m_pos + 1 == m_off) begin m_hunt = 1'b1; m_pos = 0; end
      else m_pos++;
    end
    check_outs(tag);
  endtask

  task automatic run(int n, string tag);
    for (int k = 0; k < n; k++) tick(tag);
  endtask

  initial begin
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0; nrec = 0;
    m_hunt = 1'b1; m_pos = 0; m_off = 1; m_rx = '0; m_tx = '0;
    rst_n = 1'b0; slot_tick = 1'b0; cc_valid = 1'b0; cc_sof = 1'b0;
    cc_eof = 1'b0; cc_bad = 1'b0; cc_word = '0; own_id = ID_W'(OWN); lead_ticks = '0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state, ticks while hunting are ignored
    check_outs("R1 reset");
    run(3, "R1 hunt ticks");

    // R3: cell for other terminals only
    add_rec(5, 1, 3, 0); add_rec(9, 4, 2, 1);
    send_cell(2, 6, -1);
    check_bit("R3 rx off after unlisted cell", rx_en, 1'b0);
    check_bit("R3 tx off after unlisted cell", tx_en, 1'b0);
    run(6, "R3");

    // R2: header-only cell is valid
    send_cell(0, 4, -1);
    check_bit("R2 header-only accepted (rx off)", rx_en, 1'b0);
    run(4, "R2");

    // R4/R5: own slots with lead 1
    lead_ticks = 4'd1;
    add_rec(OWN, 3, 2, 0); add_rec(OWN, 6, 1, 1); add_rec(7, 2, 5, 0);
    send_cell(3, 9, -1);
    check_outs("R5 start");
    run(9, "R4 R5");

    // R6: abutting and overlapping rx records, lead 0
    lead_ticks = 4'd0;
    add_rec(OWN, 2, 2, 0); add_rec(OWN, 4, 3, 0); add_rec(OWN, 5, 2, 0);
    send_cell(3, 10, -1);
    for (int k = 0; k < 9; k++) begin
      tick("R6 merge");
      if (m_pos >= 2 && m_pos <= 6) check_bit("R6 continuous rx_en", rx_en, 1'b1);
    end
    run(1, "R6");

    // R10: slot 0 and slots past the offset are clipped
    add_rec(OWN, 0, 3, 0); add_rec(OWN, 7, 6, 1);
    send_cell(2, 9, -1);
    check_bit("R10 slot 0 not active", rx_slot, 1'b0);
    run(9, "R10");

    // R7: lead reaching the next cell, then a missed cell
    lead_ticks = 4'd3;
    send_cell(0, 5, -1);
    check_bit("R7 rx off before lead window", rx_en, 1'b0);
    run(5, "R7 lead to next cell");
    check_bit("R7 hunting after offset", rx_en, 1'b1);
    run(4, "R7 missed cell");

    // R8: discarded cells
    lead_ticks = 4'd0;
    add_rec(OWN, 1, 2, 0); add_rec(3, 2, 2, 0);
    send_cell(2, 6, 2);
    check_bit("R8 bad word keeps rx on", rx_en, 1'b1);
    run(2, "R8 bad");
    add_rec(OWN, 1, 2, 0);
    send_cell(3, 6, -1);
    check_bit("R8 count mismatch keeps rx on", rx_en, 1'b1);
    run(2, "R8 count");
    send_cell(0, 0, -1);
    check_bit("R8 zero offset keeps rx on", rx_en, 1'b1);
    run(2, "R8 offset");

    // R9: a cell arriving mid-frame is ignored
    add_rec(OWN, 4, 2, 1);
    send_cell(1, 8, -1);
    run(2, "R9 before");
    add_rec(OWN, 1, 7, 0);
    send_cell(1, 15, -1);
    check_outs("R9 ignored cell");
    run(6, "R9 after");

    // random frames
    for (int f = 0; f < 80; f++) begin
      int n, off, bad;
      lead_ticks = SLOT_W'($urandom_range(0, 3));
      n   = $urandom_range(0, 5);
      off = $urandom_range(1, 15);
      for (int k = 0; k < n; k++)
        add_rec(($urandom_range(0, 1) != 0) ? OWN : $urandom_range(0, 63),
                $urandom_range(0, 15), $urandom_range(0, 5), $urandom_range(0, 1));
      bad = ($urandom_range(0, 9) == 0) ? 0 : -1;
      send_cell(n, off, bad);
      check_outs("R2 random accept");
      run(off + 1, "R5 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule